// File: doc/BRIEF.md
# Embedded Controller Register Access Engine

This engine lets on-chip logic read or write one register of an embedded controller through the controller's byte-wide port pair. One port carries commands and returns status when read. The other carries address and data bytes. A requester offers a request with a direction flag, an 8-bit register address and, for a write, an 8-bit value. The engine then runs the whole byte handshake without further help and reports the result.

Each byte moved across the ports is gated by a status check. The engine reads the status port and repeats that read once per microsecond until the controller is ready. The microsecond is counted in clock cycles. Only a bounded number of status reads is allowed for each byte. If the controller is still not ready after the last one, the request ends at once with an error. When a request finishes, a one-cycle completion pulse comes out with an error flag and, for reads, the returned byte.

Top module: `ec_host_xfer`

## Requirements
- R1: After reset the engine is idle (`idle`=1), with `done`=0, `io_rd`=0 and `io_wr`=0.
- R2: A request is taken only at a rising edge where `idle`=1 and `req_valid`=1. Changes on the request inputs while a request is running have no effect on the port traffic or the result of that request.
- R3: Before every byte written to either port, the engine reads the status port (`io_sel`=1, `io_rd`=1). It writes only after a status read in which bit 1 (input buffer full) was 0.
- R4: Before reading the data port (`io_sel`=0, `io_rd`=1), the engine reads the status port until bit 0 (output buffer full) reads 1. During this wait, bit 1 is ignored.
- R5: Consecutive status reads within one wait are exactly `CYC_PER_US` clock cycles apart. A single wait makes at most `MAX_POLLS` status reads.
- R6: A read request writes 0x80 to the command port (`io_sel`=1), then writes the address to the data port (`io_sel`=0), then reads the data port. The byte read appears on `rd_data` while `done` is high.
- R7: A write request writes 0x81 to the command port, then the address to the data port, then the data byte to the data port.
- R8: If `MAX_POLLS` status reads in one wait all find the controller not ready, the engine performs no further port access for that request. It raises `done` with `err`=1 in the cycle after the last status read.
- R9: `done` is high for exactly one cycle per accepted request, with `err`=0 on success. The engine is idle in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_write | input | 1 | 1 = register write, 0 = register read |
| req_addr | input | 8 | Controller register address |
| req_wdata | input | 8 | Value to write |
| idle | output | 1 | Engine can take a request |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Timeout flag, valid with `done` |
| rd_data | output | 8 | Byte returned by a read, valid with `done` |
| io_sel | output | 1 | Port select: 1 = command/status port, 0 = data port |
| io_rd | output | 1 | Port read strobe for this cycle |
| io_wr | output | 1 | Port write strobe for this cycle |
| io_wdata | output | 8 | Byte driven on a port write |
| io_rdata | input | 8 | Byte returned by the selected port in the same cycle |

## Verification
The bench models the controller, and for each of the three waits in a request it sets how many status reads report "not ready". Reads and writes with zero delay check the bare byte order and the command codes. Unequal delays per phase separate the poll counting from the phase sequencing, and the measured latency shows the poll spacing. A delay of one below the limit and a delay at the limit sit on either side of the timeout boundary. Timeouts placed in the first, middle and final phase show that nothing follows an abandoned wait. During input-buffer waits the model leaves the output-full bit set, and during the output-full wait it keeps the input bit clear, so checking the wrong bit in either wait changes the poll count. A request held and altered while the engine is busy shows that the running request is unaffected.

// File: rtl/ec_host_xfer.sv
module ec_host_xfer #(
  parameter int CYC_PER_US = 100,
  parameter int MAX_POLLS  = 500
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic       req_write,
  input  logic [7:0] req_addr,
  input  logic [7:0] req_wdata,
  output logic       idle,
  output logic       done,
  output logic       err,
  output logic [7:0] rd_data,
  output logic       io_sel,
  output logic       io_rd,
  output logic       io_wr,
  output logic [7:0] io_wdata,
  input  logic [7:0] io_rdata
);
  // CYC_PER_US must be at least 2
  localparam int PW = (MAX_POLLS > 1) ? $clog2(MAX_POLLS) : 1;
  localparam int DW = (CYC_PER_US > 2) ? $clog2(CYC_PER_US) : 1;
  localparam logic [7:0] CMD_READ  = 8'h80;
  localparam logic [7:0] CMD_WRITE = 8'h81;

  typedef enum logic [2:0] {S_IDLE, S_POLL, S_GAP, S_ACT, S_FIN} state_t;

  state_t        st;
  logic [1:0]    step;
  logic          is_wr;
  logic [7:0]    addr_q, data_q, rd_q;
  logic          err_q;
  logic [PW-1:0] polls;
  logic [DW-1:0] dly;

  logic waiting_obf, stat_ok;
  assign waiting_obf = !is_wr && (step == 2'd2);
  assign stat_ok     = waiting_obf ? io_rdata[0] : !io_rdata[1];

  assign idle    = (st == S_IDLE);
  assign done    = (st == S_FIN);
  assign err     = err_q;
  assign rd_data = rd_q;

  assign io_rd    = (st == S_POLL) || (st == S_ACT && waiting_obf);
  assign io_wr    = (st == S_ACT) && !waiting_obf;
  assign io_sel   = (st == S_POLL) || (st == S_ACT && step == 2'd0);
  assign io_wdata = (step == 2'd0) ? (is_wr ? CMD_WRITE : CMD_READ) :
                    (step == 2'd1) ? addr_q : data_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      step   <= '0;
      is_wr  <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
      rd_q   <= '0;
      err_q  <= 1'b0;
      polls  <= '0;
      dly    <= '0;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          is_wr  <= req_write;
          addr_q <= req_addr;
          data_q <= req_wdata;
          rd_q   <= '0;
          err_q  <= 1'b0;
          step   <= '0;
          polls  <= '0;
          st     <= S_POLL;
        end
        S_POLL: begin
          if (stat_ok) begin
            st <= S_ACT;
          end else if (polls == PW'(MAX_POLLS - 1)) begin
            err_q <= 1'b1;
            st    <= S_FIN;
          end else begin
            polls <= polls + 1'b1;
            dly   <= DW'(CYC_PER_US - 2);
            st    <= S_GAP;
          end
        end
        S_GAP: begin
          if (dly == '0) st <= S_POLL;
          else           dly <= dly - 1'b1;
        end
        S_ACT: begin
          if (waiting_obf) rd_q <= io_rdata;
          if (step == 2'd2) begin
            st <= S_FIN;
          end else begin
            step  <= step + 1'b1;
            polls <= '0;
            st    <= S_POLL;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_write_after_ready_R3: assert property (@(posedge clk) disable iff (!rst_n)
    io_wr |-> $past(io_rd && io_sel && !io_rdata[1]));

  assert_read_after_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && !io_sel) |-> $past(io_rd && io_sel && io_rdata[0]));

  assert_gap_after_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && io_sel && !stat_ok) |=> (!io_rd && !io_wr));

  assert_timeout_stops_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err) |-> $past(io_rd && io_sel));

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && idle));

  assert_one_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(io_rd && io_wr));
endmodule

// File: tb/test_ec_host_xfer.sv
module test_ec_host_xfer;
  localparam int C = 3;
  localparam int M = 6;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0;
  logic [7:0] req_addr = 0, req_wdata = 0;
  logic idle, done, err, io_sel, io_rd, io_wr;
  logic [7:0] rd_data, io_wdata, io_rdata;

  always #2.5 clk = ~clk;

  ec_host_xfer #(.CYC_PER_US(C), .MAX_POLLS(M)) i_ec_host_xfer (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .idle(idle), .done(done),
    .err(err), .rd_data(rd_data), .io_sel(io_sel), .io_rd(io_rd), .io_wr(io_wr),
    .io_wdata(io_wdata), .io_rdata(io_rdata));

  // controller model
  int need [3];
  logic cur_wr;
  logic [7:0] rd_val;
  int polls_ph, acc, acc_base, total_polls;
  logic [8:0] log_q [256];
  int stp;
  always_comb stp = (acc - acc_base > 2) ? 2 : acc - acc_base;
  always_comb begin
    if (!io_sel) io_rdata = rd_val;
    else if (!cur_wr && stp == 2) io_rdata = {7'b0, polls_ph >= need[2]};
    else io_rdata = {6'b0, polls_ph < need[stp], 1'b1};
  end
  always @(posedge clk) begin
    if (!rst_n) begin
      polls_ph <= 0; acc <= 0; acc_base <= 0; total_polls <= 0;
    end else begin
      if (idle && req_valid) begin polls_ph <= 0; acc_base <= acc; end
      else if (io_rd && io_sel) begin polls_ph <= polls_ph + 1; total_polls <= total_polls + 1; end
      else if (io_wr || (io_rd && !io_sel)) begin
        polls_ph <= 0; acc <= acc + 1;
        log_q[acc[7:0]] <= {io_sel, io_wr ? io_wdata : 8'h00};
      end
    end
  end

  int n_chk = 0, n_bad = 0;
  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  typedef struct packed {
    logic wr; logic [7:0] addr; logic [7:0] data; logic [7:0] rdv;
    logic [3:0] n0; logic [3:0] n1; logic [3:0] n2;
  } vec_t;
  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 8'h3C, 8'h00, 8'hA5, 4'd0, 4'd0, 4'd0},
    '{1'b1, 8'h10, 8'h7E, 8'h00, 4'd1, 4'd2, 4'd0},
    '{1'b0, 8'hFF, 8'h00, 8'h5A, 4'd0, 4'd3, 4'd4},
    '{1'b1, 8'h00, 8'hFF, 8'h00, 4'd5, 4'd5, 4'd5},
    '{1'b0, 8'h21, 8'h00, 8'h11, 4'd6, 4'd0, 4'd0},
    '{1'b1, 8'h22, 8'h33, 8'h00, 4'd0, 4'd6, 4'd0},
    '{1'b0, 8'h44, 8'h00, 8'h99, 4'd0, 4'd0, 4'd6},
    '{1'b1, 8'h55, 8'h66, 8'h00, 4'd2, 4'd0, 4'd9}
  };

  task automatic run(vec_t v, bit disturb);
    int base_acc, base_polls, lat, exp_lat, exp_polls, exp_acc, fail_step;
    logic [8:0] exp_log [3];
    bit got_done, got_err;
    logic [7:0] got_rd;
    need[0] = v.n0; need[1] = v.n1; need[2] = v.n2;
    cur_wr = v.wr; rd_val = v.rdv;
    fail_step = 3;
    for (int i = 2; i >= 0; i--) if (need[i] >= M) fail_step = i;
    exp_lat = 1; exp_polls = 0;
    for (int i = 0; i < 3; i++) begin
      if (i < fail_step) begin exp_lat += need[i] * C + 2; exp_polls += need[i] + 1; end
      else if (i == fail_step) begin exp_lat += (M - 1) * C + 1; exp_polls += M; end
    end
    exp_acc = fail_step;
    exp_log[0] = {1'b1, v.wr ? 8'h81 : 8'h80};
    exp_log[1] = {1'b0, v.addr};
    exp_log[2] = {1'b0, v.wr ? v.data : 8'h00};
    @(negedge clk);
    base_acc = acc; base_polls = total_polls;
    req_valid = 1; req_write = v.wr; req_addr = v.addr; req_wdata = v.data;
    lat = 0; got_done = 0;
    while (!got_done && lat < 2000) begin
      @(negedge clk); lat++;
      if (disturb) begin req_write = ~v.wr; req_addr = ~v.addr; req_wdata = ~v.data; end
      else req_valid = 0;
      if (done) begin got_done = 1; got_err = err; got_rd = rd_data; end
    end
    req_valid = 0;
    check("R9 done seen", got_done, 1);
    check("R5 latency/spacing", lat, exp_lat);
    check("R8/R9 err flag", got_err, fail_step < 3);
    check("R3/R4 status polls", total_polls - base_polls, exp_polls);
    check("R8 port accesses", acc - base_acc, exp_acc);
    for (int i = 0; i < 3; i++)
      if (i < exp_acc)
        check(v.wr ? "R7 write byte order" : "R6 read byte order",
              log_q[8'(base_acc + i)], exp_log[i]);
    if (!v.wr && fail_step == 3) check("R6 rd_data", got_rd, v.rdv);
    @(negedge clk);
    check("R9 done one cycle", done, 0);
    check("R9 idle after done", idle, 1);
    if (disturb) check("R2 no extra request", acc - base_acc, exp_acc);
  endtask

  initial begin
    cur_wr = 0; rd_val = 0; need[0] = 0; need[1] = 0; need[2] = 0;
    repeat (3) @(negedge clk);
    check("R1 idle", idle, 1);
    check("R1 done", done, 0);
    check("R1 strobes", {io_rd, io_wr}, 0);
    rst_n = 1;
    @(negedge clk);
    check("R1 idle after release", idle, 1);
    for (int k = 0; k < NV; k++) run(VECS[k], 0);
    run('{1'b1, 8'hA7, 8'h5C, 8'h00, 4'd1, 4'd1, 4'd1}, 1);
    run('{1'b0, 8'h0F, 8'h00, 8'hC3, 4'd2, 4'd0, 4'd1}, 1);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #(200000 * 5);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule